// File: doc/BRIEF.md
# Data-Clock to DAC-Clock Sample Synchronizer

This block moves samples from the domain of an incoming data clock into the DAC clock domain. The two clocks run at the same frequency, but their phase relationship is unknown and may wander. Samples pass through a small ring buffer. The write pointer crosses into the DAC domain in Gray code. The read side holds its pointer a fixed number of entries behind the synchronised write pointer, so that a slip of one data-clock period in either direction loses no sample.

After the asynchronous reset is released, each side first brings the reset into its own clock. The write side then waits a fixed number of data-clock edges before it stores anything. The read side locks once enough entries have arrived. Until lock, the output holds a parameterised idle code, which by default is the signed mid-scale value 0x0000. After lock the read side checks the pointer separation on every DAC clock. When the separation leaves the tolerance window, the read side re-centres its pointer and raises a flag that stays set until the next reset.

Top module: `dac_phase_sync`

## Requirements
- R1: While `arst_n` is low, and afterwards until `locked` rises, `dac_out` equals IDLE_CODE (default 16'h0000), and `locked` and `slip_flag` are 0. A new reset clears a previously set `slip_flag`.
- R2: The first sample stored is the one present on the 7th rising `data_clk` edge after `arst_n` rises: 2 edges of reset synchronisation plus ARM_EDGES = 4 arming edges, with the store on the edge after that. This sample is the first value on `dac_out` once `locked` is 1.
- R3: `locked` rises when the synchronised write pointer is CENTER = 2 entries ahead of the read pointer. It then stays at 1 until reset.
- R4: Once locked, each DAC clock cycle puts the next stored sample on `dac_out`, in order, with none skipped or repeated, while the phase of `data_clk` stays within one period of its value at lock.
- R5: A phase wander of one data-clock period, early or late, leaves `slip_flag` at 0.
- R6: If the separation (synchronised write pointer minus read pointer, modulo DEPTH) falls below CENTER-1 = 1, `slip_flag` is set on the next DAC clock edge and the read pointer is re-centred. After that, ordered output resumes from a recently stored sample.
- R7: If the separation rises above CENTER+1 = 3, the same flagging and re-centring takes place, and ordered output resumes.
- R8: Once set, `slip_flag` stays at 1 until `arst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_clk | input | 1 | Clock of the incoming sample stream |
| data_in | input | DATA_W (16) | Sample, captured on rising `data_clk` |
| dac_clk | input | 1 | DAC conversion clock, same frequency as `data_clk` |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| dac_out | output | DATA_W (16) | Sample in the DAC domain, registered on `dac_clk` |
| locked | output | 1 | Read side has locked to the write stream |
| slip_flag | output | 1 | Sticky: separation left the tolerance window at least once |

## Verification
In one DAC cycle the read side can both serve a sample and detect a separation outside the window. In that cycle the sample must come from the re-centred address and not from the stale pointer. The bench provokes this by halting `data_clk` for two periods, which drives the separation to zero, and by squeezing four data edges into two periods, which drives it to four. It then judges that `slip_flag` went high and that the output continues as an unbroken run of bench-computed samples, starting from one of the most recently sent. A single one-period halt or burst puts the separation exactly on the window edge while reads continue. There the bench requires that every sample still arrives in order and that no flag is raised.

// File: rtl/pss_pkg.sv
`timescale 1ns/100ps
package pss_pkg;

  localparam int unsigned PS_MAXW = 16;

  typedef logic [PS_MAXW-1:0] ps_word_t;

  typedef enum logic {
    RD_WAIT = 1'b0,
    RD_RUN  = 1'b1
  } ps_rd_state_e;

  // binary to reflected Gray
  function automatic ps_word_t ps_bin2gray(input ps_word_t b);
    return b ^ (b >> 1);
  endfunction

  // Gray back to binary by a log-depth prefix XOR
  function automatic ps_word_t ps_gray2bin(input ps_word_t g);
    ps_word_t b;
    b = g;
    for (int s = 1; s < int'(PS_MAXW); s = s * 2) begin
      b = b ^ (b >> s);
    end
    return b;
  endfunction

  // distance from lag up to lead on a ring of 2**aw entries
  function automatic ps_word_t ps_ring_dist(input ps_word_t lead, input ps_word_t lag,
                                            input int unsigned aw);
    ps_word_t mask;
    mask = ps_word_t'((32'd1 << aw) - 32'd1);
    return (lead - lag) & mask;
  endfunction

  // separation outside centre +/- tol
  function automatic logic ps_outside(input int unsigned sep, input int unsigned centre,
                                      input int unsigned tol);
    return ((sep + tol) < centre) || (sep > (centre + tol));
  endfunction

endpackage

// File: rtl/pss_rst_sync.sv
`timescale 1ns/100ps
module pss_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain;

  // assert at once, release after STAGES edges of clk
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain <= '0;
    end else begin
      chain <= (chain << 1) | STAGES'(1);
    end
  end

  assign rst_n_o = chain[STAGES-1];

endmodule

// File: rtl/pss_wr_side.sv
`timescale 1ns/100ps
module pss_wr_side
  import pss_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned AW        = 3,
  parameter int unsigned ARM_EDGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [AW-1:0]     wr_gray
);

  localparam int unsigned CW = $clog2(ARM_EDGES + 1);

  logic [CW-1:0] arm_cnt;
  logic          armed;
  logic [AW-1:0] wptr;
  logic [AW-1:0] wptr_nxt;
  logic [AW-1:0] gray_q;

  assign armed    = (arm_cnt == CW'(ARM_EDGES));
  assign wptr_nxt = wptr + AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_cnt <= '0;
      wptr    <= '0;
      gray_q  <= '0;
    end else begin
      if (!armed) begin
        arm_cnt <= arm_cnt + CW'(1);
      end
      if (armed) begin
        wptr   <= wptr_nxt;
        gray_q <= AW'(ps_bin2gray(PS_MAXW'(wptr_nxt)));
      end
    end
  end

  assign wr_en   = armed;
  assign wr_addr = wptr;
  assign wr_data = din;
  assign wr_gray = gray_q;

  AST_NO_STORE_BEFORE_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (wptr == '0)); // R2

  AST_GRAY_SINGLE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($countones(gray_q ^ $past(gray_q)) <= 1)); // R4

endmodule

// File: rtl/pss_ram.sv
`timescale 1ns/100ps
module pss_ram #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AW     = 3
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pss_ptr_sync.sv
`timescale 1ns/100ps
module pss_ptr_sync
  import pss_pkg::*;
#(
  parameter int unsigned AW     = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] gray_in,
  output logic [AW-1:0] bin_out
);

  for (genvar i = 0; i < int'(STAGES); i++) begin : g_stage
    logic [AW-1:0] q;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= gray_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= g_stage[i-1].q;
      end
    end
  end

  assign bin_out = AW'(ps_gray2bin(PS_MAXW'(g_stage[STAGES-1].q)));

endmodule

// File: rtl/pss_rd_side.sv
`timescale 1ns/100ps
module pss_rd_side
  import pss_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned AW        = 3,
  parameter int unsigned CENTER    = 2,
  parameter int unsigned TOL       = 1,
  parameter logic [DATA_W-1:0] IDLE_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     wbin,
  input  logic [DATA_W-1:0] rdata,
  output logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] dout,
  output logic              locked,
  output logic              slip
);

  ps_rd_state_e  state;
  logic [AW-1:0] rptr;
  logic [AW-1:0] sep;
  logic [AW-1:0] anchor;
  logic [AW-1:0] rd_dist;
  logic          lock_evt;
  logic          out_of_win;
  logic          recentre;

  // named events for the checks below
  assign sep        = AW'(ps_ring_dist(PS_MAXW'(wbin), PS_MAXW'(rptr), AW));
  assign lock_evt   = (state == RD_WAIT) && (32'(wbin) >= CENTER);
  assign out_of_win = (state == RD_RUN) && ps_outside(32'(sep), CENTER, TOL);
  assign recentre   = lock_evt || out_of_win;
  assign anchor     = wbin - AW'(CENTER);
  assign raddr      = recentre ? anchor : rptr;
  assign rd_dist    = AW'(ps_ring_dist(PS_MAXW'(wbin), PS_MAXW'(raddr), AW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RD_WAIT;
      rptr  <= '0;
      dout  <= IDLE_CODE;
      slip  <= 1'b0;
    end else begin
      if (recentre) begin
        rptr <= anchor + AW'(1);
      end else if (state == RD_RUN) begin
        rptr <= rptr + AW'(1);
      end
      if (lock_evt) begin
        state <= RD_RUN;
      end
      dout <= (lock_evt || (state == RD_RUN)) ? rdata : IDLE_CODE;
      slip <= slip | out_of_win;
    end
  end

  assign locked = (state == RD_RUN);

  AST_IDLE_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_WAIT) |-> (dout == IDLE_CODE)); // R1

  AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RD_RUN) |=> (state == RD_RUN)); // R3

  AST_READ_BEHIND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_evt || (state == RD_RUN)) |-> (rd_dist != '0)); // R4

  AST_FLAG_ON_EXCURSION: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_win |=> slip); // R6

  AST_RECENTRE_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_win |=> !out_of_win); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    slip |=> slip); // R8

endmodule

// File: rtl/dac_phase_sync.sv
`timescale 1ns/100ps
module dac_phase_sync #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned ARM_EDGES   = 4,
  parameter int unsigned CENTER      = 2,
  parameter int unsigned TOL         = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] IDLE_CODE = '0
) (
  input  logic              data_clk,
  input  logic [DATA_W-1:0] data_in,
  input  logic              dac_clk,
  input  logic              arst_n,
  output logic [DATA_W-1:0] dac_out,
  output logic              locked,
  output logic              slip_flag
);

  localparam int unsigned AW = $clog2(DEPTH);

  logic              wrst_n;
  logic              rrst_n;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [AW-1:0]     wr_gray;
  logic [AW-1:0]     wbin_sync;
  logic [AW-1:0]     rd_addr;
  logic [DATA_W-1:0] rd_data;

  pss_rst_sync #(.STAGES(SYNC_STAGES)) i_wrst (
    .clk(data_clk), .arst_n(arst_n), .rst_n_o(wrst_n)
  );

  pss_rst_sync #(.STAGES(SYNC_STAGES)) i_rrst (
    .clk(dac_clk), .arst_n(arst_n), .rst_n_o(rrst_n)
  );

  pss_wr_side #(.DATA_W(DATA_W), .AW(AW), .ARM_EDGES(ARM_EDGES)) i_wr (
    .clk(data_clk), .rst_n(wrst_n), .din(data_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_gray(wr_gray)
  );

  pss_ram #(.DATA_W(DATA_W), .AW(AW)) i_ram (
    .wclk(data_clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  pss_ptr_sync #(.AW(AW), .STAGES(SYNC_STAGES)) i_psync (
    .clk(dac_clk), .rst_n(rrst_n), .gray_in(wr_gray), .bin_out(wbin_sync)
  );

  pss_rd_side #(
    .DATA_W(DATA_W), .AW(AW), .CENTER(CENTER), .TOL(TOL), .IDLE_CODE(IDLE_CODE)
  ) i_rd (
    .clk(dac_clk), .rst_n(rrst_n), .wbin(wbin_sync), .rdata(rd_data),
    .raddr(rd_addr), .dout(dac_out), .locked(locked), .slip(slip_flag)
  );

endmodule

// File: tb/test_dac_phase_sync.sv
`timescale 1ns/100ps
module test_dac_phase_sync;

  localparam logic [15:0] IDLE = 16'h0000;
  localparam int FIRST_IDX = 6; // 2 sync edges + 4 arming edges, stored on the next edge

  logic        data_clk = 1'b0;
  logic        dac_clk  = 1'b0;
  logic        arst_n   = 1'b0;
  logic [15:0] data_in  = 16'h0000;
  logic [15:0] dac_out;
  logic        locked;
  logic        slip_flag;

  int checks   = 0;
  int fails    = 0;
  int hold_req = 0;
  int fast_req = 0;
  int ecount   = 0;
  int exp_k    = 0;
  logic [15:0] salt = 16'h0000;

  dac_phase_sync i_dac_phase_sync (
    .data_clk(data_clk), .data_in(data_in), .dac_clk(dac_clk), .arst_n(arst_n),
    .dac_out(dac_out), .locked(locked), .slip_flag(slip_flag)
  );

  // bijective scramble of the sample index
  function automatic logic [15:0] sample_of(input int j);
    return 16'(j * 40503) ^ salt;
  endfunction

  initial begin
    forever begin
      #5 dac_clk = ~dac_clk;
    end
  end

  // data clock: fixed random phase, with requested pauses and double-rate bursts
  initial begin
    int sel;
    int ofs;
    salt = 16'($urandom(32'd24681));
    sel  = int'($urandom_range(0, 7));
    ofs  = (sel < 4) ? sel + 1 : sel + 2;
    #(ofs);
    forever begin
      if (hold_req > 0) begin
        #10;
        hold_req--;
      end else if (fast_req > 0) begin
        data_clk = 1'b1; #2.5 data_clk = 1'b0; #2.5
        data_clk = 1'b1; #2.5 data_clk = 1'b0; #2.5;
        fast_req--;
      end else begin
        data_clk = 1'b1; #5 data_clk = 1'b0; #5;
      end
    end
  end

  initial begin
    forever begin
      @(posedge data_clk);
      if (arst_n) ecount++;
    end
  end

  initial begin
    forever begin
      @(negedge data_clk);
      data_in = sample_of(ecount);
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge dac_clk);
  endtask

  task automatic apply_reset();
    arst_n = 1'b0;
    ecount = 0;
    repeat (4) tick();
    check(dac_out === IDLE, "R1", "output in reset", 32'(dac_out), 32'(IDLE));
    check(locked === 1'b0, "R1", "locked in reset", 32'(locked), 0);
    check(slip_flag === 1'b0, "R1", "flag in reset (R8 cleared)", 32'(slip_flag), 0);
    data_in = sample_of(0);
    arst_n = 1'b1;
  endtask

  task automatic wait_lock();
    bit idle_ok;
    int n;
    idle_ok = 1'b1;
    n = 0;
    while (!locked && n < 60) begin
      tick();
      n++;
      if (!locked && dac_out !== IDLE) idle_ok = 1'b0;
    end
    check(idle_ok, "R1", "idle code before lock", 32'(dac_out), 32'(IDLE));
    check(locked === 1'b1, "R3", "lock reached", 32'(locked), 1);
    check(dac_out === sample_of(FIRST_IDX), "R2", "first sample after lock",
          32'(dac_out), 32'(sample_of(FIRST_IDX)));
    exp_k = FIRST_IDX;
  endtask

  task automatic follow(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      tick();
      exp_k++;
      check(dac_out === sample_of(exp_k), req, "ordered sample",
            32'(dac_out), 32'(sample_of(exp_k)));
    end
    check(locked === 1'b1, "R3", "lock held", 32'(locked), 1);
  endtask

  task automatic relock(input string req);
    bit found;
    found = 1'b0;
    for (int j = ecount; j >= 0 && j > ecount - 32; j--) begin
      if (!found && sample_of(j) === dac_out) begin
        found = 1'b1;
        exp_k = j;
      end
    end
    check(found, req, "output is a recent sample after re-centre", 32'(dac_out), 0);
  endtask

  initial begin
    int p;
    apply_reset();
    wait_lock();

    // R4/R5: random one-period wander, never beyond +/-1
    p = 0;
    for (int i = 0; i < 1500; i++) begin
      tick();
      exp_k++;
      check(dac_out === sample_of(exp_k), "R4", "ordered under wander",
            32'(dac_out), 32'(sample_of(exp_k)));
      if (hold_req == 0 && fast_req == 0 && $urandom_range(0, 19) == 0) begin
        if (p == 0) begin
          if ($urandom_range(0, 1) == 0) begin hold_req = 1; p = -1; end
          else begin fast_req = 1; p = 1; end
        end else if (p < 0) begin
          fast_req = 1; p = 0;
        end else begin
          hold_req = 1; p = 0;
        end
      end
    end
    if (p < 0) fast_req = 1;
    if (p > 0) hold_req = 1;
    follow(40, "R4");
    check(slip_flag === 1'b0, "R5", "no flag under one-period wander", 32'(slip_flag), 0);

    // R6: data clock halts two periods
    hold_req = 2;
    repeat (12) tick();
    check(slip_flag === 1'b1, "R6", "flag after halt", 32'(slip_flag), 1);
    relock("R6");
    follow(60, "R6");
    check(slip_flag === 1'b1, "R8", "flag still set", 32'(slip_flag), 1);

    // reset mid-stream clears everything and relocks
    apply_reset();
    wait_lock();
    follow(100, "R4");
    check(slip_flag === 1'b0, "R5", "flag clear before burst", 32'(slip_flag), 0);

    // R7: burst of four edges in two periods
    fast_req = 2;
    repeat (12) tick();
    check(slip_flag === 1'b1, "R7", "flag after burst", 32'(slip_flag), 1);
    relock("R7");
    follow(60, "R7");
    check(slip_flag === 1'b1, "R8", "flag sticky after burst", 32'(slip_flag), 1);

    summary();
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule